// File: doc/BRIEF.md
# Register Window Pointer and Trap Control

This block keeps the current window pointer and the invalid-window mask of a processor whose integer registers are arranged as a ring of overlapping windows. Each cycle it may receive one of five commands: save, restore, trap entry, return-from-trap, or a mask write. Several commands may arrive together, and a fixed priority then picks one. Save and trap entry move the pointer one window down. Restore and return-from-trap move it one window up. Every move wraps around the ring of `NWIN` windows.

Before a save, restore or return-from-trap moves the pointer, the block looks up the destination window in the mask. If that window is marked invalid, the pointer stays where it is. A one-cycle pulse then reports the fault: overflow when the move was downward, underflow when it was upward. Trap entry is never checked, so a handler always gets a window to run in. The pointer and the mask drive the register file's window addressing directly.

Top module: `win_ptr_ctl`

## Requirements
- R1: After synchronous reset, the pointer is 0, the mask is 0 and both fault pulses are low.
- R2: A save whose destination window is valid sets the pointer to pointer-1, and a save from 0 goes to NWIN-1.
- R3: A restore whose destination window is valid sets the pointer to pointer+1, and a restore from NWIN-1 goes to 0.
- R4: A save whose destination window has its mask bit set raises `ovf_o` for exactly one cycle and leaves the pointer unchanged.
- R5: A restore or return-from-trap whose destination window has its mask bit set raises `unf_o` for exactly one cycle and leaves the pointer unchanged.
- R6: Trap entry decrements the pointer modulo NWIN without consulting the mask, even when it lands on an invalid window, and it raises no fault pulse.
- R7: A return-from-trap whose destination window is valid increments the pointer modulo NWIN.
- R8: A mask write stores `wim_wdata_i` bit i in mask bit i for every i below NWIN. Mask bits at NWIN and above always read 0. The write does not move the pointer.
- R9: With the mask all zero, no save, restore or return-from-trap raises a fault pulse.
- R10: When several commands are asserted in one cycle, only one takes effect. The order from highest to lowest is mask write, trap entry, return-from-trap, save, restore.
- R11: `ovf_o` and `unf_o` are never high together, and each is high only in the cycle after the command that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| save_i | input | 1 | Save command (move down, checked) |
| restore_i | input | 1 | Restore command (move up, checked) |
| trap_i | input | 1 | Trap entry command (move down, unchecked) |
| rett_i | input | 1 | Return-from-trap command (move up, checked) |
| wim_we_i | input | 1 | Mask write strobe |
| wim_wdata_i | input | 32 | Mask write data |
| cwp_o | output | 5 | Current window pointer |
| wim_o | output | 32 | Invalid-window mask, bits at NWIN and above read 0 |
| ovf_o | output | 1 | One-cycle window overflow pulse |
| unf_o | output | 1 | One-cycle window underflow pulse |

## Verification
The bench builds the block with NWIN = 5. With that count, the wrap from 0 to 4 and from 4 to 0 differs from a power-of-two wrap, so a design that wraps by truncating bits produces a wrong pointer. It also leaves 27 mask bits above the window count, so the bench can write ones into those bits and check that they never reach `wim_o`. Directed sequences cover each fault direction, trap entry onto an invalid window, and every pairing in the priority order. Random command mixes follow, checked every cycle against a behavioural model.

// File: rtl/win_ctl_pkg.sv
package win_ctl_pkg;

    localparam int PTR_W = 5;
    localparam int WIM_W = 32;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_WIMWR,
        OP_TRAP,
        OP_RETT,
        OP_SAVE,
        OP_RESTORE
    } win_op_e;

    typedef struct packed {
        logic [PTR_W-1:0] cwp;
        logic             ovf;
        logic             unf;
    } step_res_t;

    function automatic logic [PTR_W-1:0] ptr_dn(logic [PTR_W-1:0] p, int unsigned n);
        return (p == '0) ? PTR_W'(n - 1) : p - 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_up(logic [PTR_W-1:0] p, int unsigned n);
        return (p == PTR_W'(n - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [WIM_W-1:0] live_mask(int unsigned n);
        logic [WIM_W-1:0] m;
        for (int i = 0; i < WIM_W; i++) m[i] = (i < n);
        return m;
    endfunction

endpackage

// File: rtl/win_op_pick.sv
module win_op_pick
    import win_ctl_pkg::*;
(
    input  logic    wim_we,
    input  logic    trap,
    input  logic    rett,
    input  logic    save,
    input  logic    restore,
    output win_op_e op
);
    // Fixed priority: mask write, trap entry, return-from-trap, save, restore (R10)
    always_comb begin
        if (wim_we)       op = OP_WIMWR;
        else if (trap)    op = OP_TRAP;
        else if (rett)    op = OP_RETT;
        else if (save)    op = OP_SAVE;
        else if (restore) op = OP_RESTORE;
        else              op = OP_NONE;
    end
endmodule

// File: rtl/win_ptr_step.sv
module win_ptr_step
    import win_ctl_pkg::*;
#(
    parameter int unsigned NWIN = 8
) (
    input  win_op_e          op,
    input  logic [PTR_W-1:0] cwp,
    input  logic [WIM_W-1:0] wim,
    output step_res_t        res
);
    logic [PTR_W-1:0] up_ptr;
    logic [PTR_W-1:0] dn_ptr;
    logic             up_bad;
    logic             dn_bad;

    assign up_ptr = ptr_up(cwp, NWIN);
    assign dn_ptr = ptr_dn(cwp, NWIN);
    assign up_bad = wim[up_ptr];
    assign dn_bad = wim[dn_ptr];

    always_comb begin
        res.cwp = cwp;
        res.ovf = 1'b0;
        res.unf = 1'b0;
        unique case (op)
            OP_TRAP: res.cwp = dn_ptr;           // unchecked move (R6)
            OP_SAVE: begin
                if (dn_bad) res.ovf = 1'b1;      // R4
                else        res.cwp = dn_ptr;    // R2
            end
            OP_RETT, OP_RESTORE: begin
                if (up_bad) res.unf = 1'b1;      // R5
                else        res.cwp = up_ptr;    // R3, R7
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/win_mask_reg.sv
module win_mask_reg
    import win_ctl_pkg::*;
#(
    parameter int unsigned NWIN = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [WIM_W-1:0] wdata,
    output logic [WIM_W-1:0] wim
);
    localparam logic [WIM_W-1:0] LIVE = live_mask(NWIN);

    always_ff @(posedge clk) begin
        if (rst)     wim <= '0;
        else if (we) wim <= wdata & LIVE;
    end

    // R8: no bit at or above the window count ever reads as set
    a_r8_upper_clear: assert property (@(posedge clk) disable iff (rst)
        (wim & ~LIVE) == '0);

    // R8: a write lands its live bits one cycle later
    a_r8_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> (wim == ($past(wdata) & LIVE)));
endmodule

// File: rtl/win_ptr_ctl.sv
module win_ptr_ctl
    import win_ctl_pkg::*;
#(
    parameter int unsigned NWIN = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        save_i,
    input  logic        restore_i,
    input  logic        trap_i,
    input  logic        rett_i,
    input  logic        wim_we_i,
    input  logic [31:0] wim_wdata_i,
    output logic [4:0]  cwp_o,
    output logic [31:0] wim_o,
    output logic        ovf_o,
    output logic        unf_o
);
    win_op_e          op;
    step_res_t        nxt;
    logic [PTR_W-1:0] cwp_q;
    logic [WIM_W-1:0] wim_q;
    logic             ovf_q;
    logic             unf_q;

    win_op_pick u_pick (
        .wim_we  (wim_we_i),
        .trap    (trap_i),
        .rett    (rett_i),
        .save    (save_i),
        .restore (restore_i),
        .op      (op)
    );

    win_mask_reg #(.NWIN(NWIN)) u_mask (
        .clk   (clk),
        .rst   (rst),
        .we    (op == OP_WIMWR),
        .wdata (wim_wdata_i),
        .wim   (wim_q)
    );

    win_ptr_step #(.NWIN(NWIN)) u_step (
        .op  (op),
        .cwp (cwp_q),
        .wim (wim_q),
        .res (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp_q <= '0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            cwp_q <= nxt.cwp;
            ovf_q <= nxt.ovf;
            unf_q <= nxt.unf;
        end
    end

    assign cwp_o = cwp_q;
    assign wim_o = wim_q;
    assign ovf_o = ovf_q;
    assign unf_o = unf_q;

    a_r2_ptr_in_range: assert property (@(posedge clk) disable iff (rst)
        cwp_q < PTR_W'(NWIN));

    a_r4_ovf_holds_ptr: assert property (@(posedge clk) disable iff (rst)
        ovf_q |-> $stable(cwp_q));

    a_r5_unf_holds_ptr: assert property (@(posedge clk) disable iff (rst)
        unf_q |-> $stable(cwp_q));

    a_r6_trap_no_fault: assert property (@(posedge clk) disable iff (rst)
        (op == OP_TRAP) |=> (!ovf_q && !unf_q && cwp_q == ptr_dn($past(cwp_q), NWIN)));

    a_r8_write_keeps_ptr: assert property (@(posedge clk) disable iff (rst)
        (op == OP_WIMWR) |=> ($stable(cwp_q) && !ovf_q && !unf_q));

    a_r9_clear_mask_no_fault: assert property (@(posedge clk) disable iff (rst)
        (wim_q == '0) |=> (!ovf_q && !unf_q));

    a_r11_one_fault: assert property (@(posedge clk) disable iff (rst)
        !(ovf_q && unf_q));

    a_r11_ovf_from_save: assert property (@(posedge clk) disable iff (rst)
        (op != OP_SAVE) |=> !ovf_q);
endmodule

// File: tb/test_win_ptr_ctl.sv
`timescale 1ns/1ps
module test_win_ptr_ctl;
    localparam int NW = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        save_i = 0, restore_i = 0, trap_i = 0, rett_i = 0, wim_we_i = 0;
    logic [31:0] wim_wdata_i = '0;
    logic [4:0]  cwp_o;
    logic [31:0] wim_o;
    logic        ovf_o, unf_o;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;

    int          m_cwp = 0;
    logic [31:0] m_wim = '0;
    bit          m_ovf = 0, m_unf = 0;
    logic [31:0] live = 32'((64'd1 << NW) - 1);

    always #2 clk = ~clk;

    win_ptr_ctl #(.NWIN(NW)) i_win_ptr_ctl (
        .clk(clk), .rst(rst),
        .save_i(save_i), .restore_i(restore_i), .trap_i(trap_i), .rett_i(rett_i),
        .wim_we_i(wim_we_i), .wim_wdata_i(wim_wdata_i),
        .cwp_o(cwp_o), .wim_o(wim_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    task automatic check(string tag);
        n_chk++;
        if (cwp_o !== 5'(m_cwp) || wim_o !== m_wim || ovf_o !== m_ovf || unf_o !== m_unf) begin
            n_fail++;
            $display("FAIL %s: got cwp=%0d wim=%h ovf=%b unf=%b, expected cwp=%0d wim=%h ovf=%b unf=%b",
                     tag, cwp_o, wim_o, ovf_o, unf_o, m_cwp, m_wim, m_ovf, m_unf);
        end
    endtask

    // Behavioural reference: one command per cycle, chosen by priority
    task automatic model_step();
        int up = (m_cwp + 1) % NW;
        int dn = (m_cwp + NW - 1) % NW;
        m_ovf = 0;
        m_unf = 0;
        if (wim_we_i) m_wim = wim_wdata_i & live;
        else if (trap_i) m_cwp = dn;
        else if (rett_i || (!save_i && restore_i)) begin
            if (m_wim[up]) m_unf = 1; else m_cwp = up;
        end else if (save_i) begin
            if (m_wim[dn]) m_ovf = 1; else m_cwp = dn;
        end
    endtask

    task automatic cyc(bit wr, logic [31:0] d, bit tr, bit rt, bit sv, bit rs, string tag);
        wim_we_i = wr; wim_wdata_i = d; trap_i = tr; rett_i = rt; save_i = sv; restore_i = rs;
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(tag);
    endtask

    task automatic idle(string tag);
        cyc(0, '0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 during reset");
        rst = 1'b0;
        idle("R1 after reset");

        // R8: upper bits dropped; window 4 invalid
        cyc(1, 32'hFFFF_FFF0, 0, 0, 0, 0, "R8 masked write");
        // R4: save from 0 lands on window 4
        cyc(0, '0, 0, 0, 1, 0, "R4 overflow");
        idle("R11 pulse ends");
        // R6: trap entry onto invalid window 4
        cyc(0, '0, 1, 0, 0, 0, "R6 unchecked trap entry");
        // R3: restore wraps 4 -> 0
        cyc(0, '0, 0, 0, 0, 1, "R3 restore wrap");
        // R5: window 1 invalid
        cyc(1, 32'h0000_0002, 0, 0, 0, 0, "R8 write bit1");
        cyc(0, '0, 0, 0, 0, 1, "R5 restore underflow");
        cyc(0, '0, 0, 1, 0, 0, "R5 rett underflow");
        idle("R11 pulse ends");
        // R9 / R2: clear mask, save all the way round
        cyc(1, 32'h0, 0, 0, 0, 0, "R9 clear mask");
        for (int k = 0; k < 6; k++) cyc(0, '0, 0, 0, 1, 0, "R2 R9 save ring");
        for (int k = 0; k < 6; k++) cyc(0, '0, 0, 0, 0, 1, "R3 R9 restore ring");
        for (int k = 0; k < 6; k++) cyc(0, '0, 0, 1, 0, 0, "R7 rett ring");
        // R10 priority pairs
        cyc(1, 32'h0000_0008, 1, 1, 1, 1, "R10 write beats all");
        cyc(0, '0, 1, 1, 1, 1, "R10 trap beats rett");
        cyc(0, '0, 0, 1, 1, 1, "R10 rett beats save");
        cyc(0, '0, 0, 0, 1, 1, "R10 save beats restore");
        cyc(1, 32'h0000_0001 << ((m_cwp + NW - 1) % NW), 0, 0, 0, 0, "R8 mark below");
        cyc(0, '0, 0, 0, 1, 1, "R10 R4 save wins and faults");
        idle("R11 pulse ends");

        for (int k = 0; k < 500; k++) begin
            int r = int'($urandom % 32);
            cyc(r == 0, 32'h1 << ($urandom % 8), r[1], r[2], r[3], r[4], "R10 R11 random mix");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule